// File: doc/BRIEF.md
# Frequency Modulation Sequencer

This block is the pitch modulator in front of a wavetable voice. It holds a ring of 32 three-bit step codes. On every sample tick (one tick per `TICK_DIV` clocks) it adds a 12-bit modulation rate to a fractional phase. A carry out of that phase moves a six-bit table position forward by one and applies the code under the position to a 7-bit signed modulation counter. Only the upper five position bits pick the entry, so each code is applied on two steps in a row.

After every tick the counter is scaled by the 6-bit modulation gain from the envelope. The product is rounded by a rule that depends on its sign, offset to a centre value of 0x40 and multiplied by the 12-bit base pitch. The result is the 20-bit pitch increment for the wave channel. A single byte-wide write port sets the base pitch, the modulation rate, the halt and force controls, the counter and the table. Registered read ports show the counter, the increment under the table position and the position itself.

Top module: `modpitch_seq`

## Requirements
- R1: After reset, `wave_pitch`, `rd_counter` and `rd_pos` all read 0, and the modulation rate, base pitch, halt and force controls are all clear.
- R2: `tick_o` pulses for one clock once every `TICK_DIV` clocks, which is 16 by default.
- R3: On each tick that is not halted, the rate is added to the 12-bit phase. A carry out of bit 11 applies the code of entry `pos[5:1]` to the counter and then advances `pos` by one. Each entry is therefore applied on two consecutive steps.
- R4: Codes 0 to 7 change the counter by 0, +1, +2, +4, set it to 0, -4, -2 and -1, in that order.
- R5: The counter is 7-bit two's complement and wraps: 63 plus 1 gives -64, and -64 minus 1 gives 63.
- R6: A write to address 4 loads `wr_data[6:0]` into the counter. It takes priority over a step in the same cycle.
- R7: Address 3 bit 7 is the halt control. While halt is set there is no stepping, the phase is held at 0 and `pos` is kept. A table write to address 5 stores `wr_data[2:0]` in entry `pos[5:1]` and then adds 2 to `pos`, so 32 writes bring `pos` back to its start. A table write while halt is clear changes nothing.
- R8: When the rate is 0 no step occurs. When address 3 bit 6 (force) is set, every non-halted tick steps, whatever the rate.
- R9: The pitch is computed as follows. t = counter×gain, taken modulo 2^12. If t[3:0] is nonzero and t[11] is 0, add 0x20. Then add 0x400. Scale = t[11:4]. `wave_pitch` = base×scale, truncated to 20 bits.
- R10: `wave_pitch` takes its new value within 10 clocks after a `tick_o` pulse. It is computed from the counter, gain and base present in the cycle of that pulse, and it holds until the next update.
- R11: `rd_counter` reads the counter with bit 7 at 0. `rd_incr` reads the increment of the entry under `pos` as 0, 1, 2, 4, C, C, E, F for codes 0 to 7. Both ports, and `rd_pos`, follow their state one clock later.
- R12: The write map is as follows. Address 0 is base pitch [7:0]. Address 1 is base pitch [11:8] from `wr_data[3:0]`. Address 2 is rate [7:0]. Address 3 holds rate [11:8] in `wr_data[3:0]`, force in bit 6 and halt in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 8 | Write data |
| gain_in | input | 6 | Modulation gain from the envelope |
| tick_o | output | 1 | Sample tick pulse, shared with the wave channel |
| wave_pitch | output | 20 | Modulated pitch increment |
| rd_counter | output | 8 | Counter readback, bit 7 zero |
| rd_incr | output | 4 | Increment for the current entry |
| rd_pos | output | 6 | Table position including the low repeat bit |

## Verification
The bench builds the block with its defaults: a 16-clock tick and a 32-entry table. With these values, a full 32-write table fill wraps the six-bit position within a few hundred clocks. Twenty forced steps then cover the repeated application of each entry and every code, including the reset code. A rate of 0x800 carries on every second tick, which makes the half-rate phase path visible in eight ticks. A 16-clock window leaves room for the eight-cycle multiply, so each pitch vector is checked before the next tick.

// File: rtl/modpitch_pkg.sv
`timescale 1ns/1ps
package modpitch_pkg;

  typedef enum logic [2:0] {
    SEL_BASE_LO  = 3'd0,
    SEL_BASE_HI  = 3'd1,
    SEL_RATE_LO  = 3'd2,
    SEL_CTRL     = 3'd3,
    SEL_COUNTER  = 3'd4,
    SEL_TABLE    = 3'd5
  } wr_sel_e;

  // Readback form of a step code (code 4 shows as C but clears the counter)
  function automatic logic [3:0] code_to_incr(input logic [2:0] code);
    case (code)
      3'd0:    return 4'h0;
      3'd1:    return 4'h1;
      3'd2:    return 4'h2;
      3'd3:    return 4'h4;
      3'd4:    return 4'hC;
      3'd5:    return 4'hC;
      3'd6:    return 4'hE;
      default: return 4'hF;
    endcase
  endfunction

endpackage

// File: rtl/modpitch_table.sv
`timescale 1ns/1ps
module modpitch_table #(
  parameter int DEPTH  = 32,
  parameter int CODE_W = 3,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] rdata
);

  logic [CODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/modpitch_stepper.sv
`timescale 1ns/1ps
module modpitch_stepper #(
  parameter int RATE_W = 12,
  parameter int CNT_W  = 7,
  parameter int POS_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              halt,
  input  logic              force_carry,
  input  logic [RATE_W-1:0] rate,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              tbl_wr,
  input  logic [2:0]        code,
  output logic              tbl_we,
  output logic [POS_W-1:0]  pos,
  output logic [CNT_W-1:0]  counter
);
  import modpitch_pkg::*;

  logic [RATE_W-1:0] phase;
  logic [RATE_W:0]   sum;
  logic              carry, step;
  logic [3:0]        incr;
  logic [CNT_W-1:0]  stepped;

  always_comb begin
    sum   = {1'b0, phase} + {1'b0, rate};
    carry = sum[RATE_W] | force_carry;
    step  = tick & ~halt & carry;
    incr  = code_to_incr(code);
    if (code == 3'd4) stepped = '0;
    else              stepped = counter + {{(CNT_W-4){incr[3]}}, incr};
  end

  assign tbl_we = tbl_wr & halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      pos     <= '0;
      counter <= '0;
    end else begin
      if (halt)      phase <= '0;
      else if (tick) phase <= sum[RATE_W-1:0];

      if (tbl_we)    pos <= pos + POS_W'(2);
      else if (step) pos <= pos + POS_W'(1);

      if (cnt_wr)    counter <= cnt_wdata;
      else if (step) counter <= stepped;
    end
  end

  // R7: position is frozen while halted unless a table write lands
  a_r7_halt_keeps_pos: assert property (@(posedge clk) disable iff (rst)
    (halt && !tbl_we) |=> $stable(pos));

  // R7: a table write advances by one whole entry
  a_r7_write_advances: assert property (@(posedge clk) disable iff (rst)
    tbl_we |=> (pos == $past(pos) + POS_W'(2)));

  // R3: stepping moves the position by at most one per clock
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    !tbl_we |=> (pos == $past(pos) || pos == $past(pos) + POS_W'(1)));

  // R5: +1 from the top value wraps to the most negative value
  a_r5_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (step && !cnt_wr && code == 3'd1 && counter == {1'b0, {(CNT_W-1){1'b1}}})
      |=> (counter == {1'b1, {(CNT_W-1){1'b0}}}));

  // R6: a CPU counter write wins over a simultaneous step
  a_r6_cpu_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (counter == $past(cnt_wdata)));

endmodule

// File: rtl/modpitch_scaler.sv
`timescale 1ns/1ps
module modpitch_scaler #(
  parameter int BASE_W  = 12,
  parameter int GAIN_W  = 6,
  parameter int CNT_W   = 7,
  parameter int PITCH_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CNT_W-1:0]   counter,
  input  logic [GAIN_W-1:0]  gain,
  input  logic [BASE_W-1:0]  base,
  output logic [PITCH_W-1:0] pitch
);
  localparam int PROD_W  = 12;
  localparam int SCALE_W = 8;
  localparam int LEFT_W  = $clog2(SCALE_W + 1);

  logic [PROD_W-1:0]  op_c, op_g, prod, rnd;
  logic [SCALE_W-1:0] scale;

  always_comb begin
    op_c  = {{(PROD_W-CNT_W){counter[CNT_W-1]}}, counter};
    op_g  = {{(PROD_W-GAIN_W){1'b0}}, gain};
    prod  = op_c * op_g;
    rnd   = ((|prod[3:0]) && !prod[PROD_W-1]) ? PROD_W'(32) : '0;
    scale = SCALE_W'((prod + rnd + PROD_W'(1024)) >> 4);
  end

  logic               busy;
  logic [LEFT_W-1:0]  left;
  logic [PITCH_W-1:0] acc, mcand, addend;
  logic [SCALE_W-1:0] mplier;

  assign addend = mplier[0] ? mcand : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      left   <= '0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      pitch  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      left   <= LEFT_W'(SCALE_W);
      acc    <= '0;
      mcand  <= {{(PITCH_W-BASE_W){1'b0}}, base};
      mplier <= scale;
    end else if (busy) begin
      acc    <= acc + addend;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
      left   <= left - LEFT_W'(1);
      if (left == LEFT_W'(1)) begin
        busy  <= 1'b0;
        pitch <= acc + addend;
      end
    end
  end

  // R10: a start always launches the sequential multiply
  a_r10_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R10: the published pitch holds between multiplies
  a_r10_pitch_holds: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(pitch));

endmodule

// File: rtl/modpitch_seq.sv
`timescale 1ns/1ps
module modpitch_seq #(
  parameter int TICK_DIV  = 16,
  parameter int TBL_DEPTH = 32,
  parameter int RATE_W    = 12,
  parameter int BASE_W    = 12,
  parameter int GAIN_W    = 6,
  parameter int CNT_W     = 7,
  parameter int PITCH_W   = 20,
  localparam int PRE_W    = $clog2(TICK_DIV),
  localparam int TADDR_W  = $clog2(TBL_DEPTH),
  localparam int POS_W    = TADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [GAIN_W-1:0]  gain_in,
  output logic               tick_o,
  output logic [PITCH_W-1:0] wave_pitch,
  output logic [CNT_W:0]     rd_counter,
  output logic [3:0]         rd_incr,
  output logic [POS_W-1:0]   rd_pos
);
  import modpitch_pkg::*;

  logic [PRE_W-1:0]  pre;
  logic              tick;
  logic [BASE_W-1:0] base;
  logic [RATE_W-1:0] rate;
  logic              halt, force_carry;
  logic              cnt_wr, tbl_wr, tbl_we;
  logic [POS_W-1:0]  pos;
  logic [CNT_W-1:0]  counter;
  logic [2:0]        code;

  assign tick   = (pre == PRE_W'(TICK_DIV - 1));
  assign cnt_wr = wr_en && (wr_addr == SEL_COUNTER);
  assign tbl_wr = wr_en && (wr_addr == SEL_TABLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre         <= '0;
      base        <= '0;
      rate        <= '0;
      halt        <= 1'b0;
      force_carry <= 1'b0;
      tick_o      <= 1'b0;
      rd_counter  <= '0;
      rd_incr     <= '0;
      rd_pos      <= '0;
    end else begin
      pre        <= tick ? '0 : pre + PRE_W'(1);
      tick_o     <= tick;
      rd_counter <= {1'b0, counter};
      rd_incr    <= code_to_incr(code);
      rd_pos     <= pos;
      if (wr_en) begin
        case (wr_addr)
          SEL_BASE_LO: base[7:0]        <= wr_data;
          SEL_BASE_HI: base[BASE_W-1:8] <= wr_data[BASE_W-9:0];
          SEL_RATE_LO: rate[7:0]        <= wr_data;
          SEL_CTRL: begin
            rate[RATE_W-1:8] <= wr_data[RATE_W-9:0];
            force_carry      <= wr_data[6];
            halt             <= wr_data[7];
          end
          default: ;
        endcase
      end
    end
  end

  modpitch_table #(.DEPTH(TBL_DEPTH), .CODE_W(3)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .addr  (pos[POS_W-1:1]),
    .wdata (wr_data[2:0]),
    .rdata (code)
  );

  modpitch_stepper #(.RATE_W(RATE_W), .CNT_W(CNT_W), .POS_W(POS_W)) u_stepper (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .halt        (halt),
    .force_carry (force_carry),
    .rate        (rate),
    .cnt_wr      (cnt_wr),
    .cnt_wdata   (wr_data[CNT_W-1:0]),
    .tbl_wr      (tbl_wr),
    .code        (code),
    .tbl_we      (tbl_we),
    .pos         (pos),
    .counter     (counter)
  );

  modpitch_scaler #(.BASE_W(BASE_W), .GAIN_W(GAIN_W), .CNT_W(CNT_W),
                    .PITCH_W(PITCH_W)) u_scaler (
    .clk     (clk),
    .rst     (rst),
    .start   (tick_o),
    .counter (counter),
    .gain    (gain_in),
    .base    (base),
    .pitch   (wave_pitch)
  );

  // R2: the tick is a single-clock pulse
  a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R11: readback bit 7 of the counter is always zero
  a_r11_counter_msb: assert property (@(posedge clk) disable iff (rst)
    !rd_counter[CNT_W]);

endmodule

// File: tb/modpitch_seq_bench.sv
`timescale 1ns/1ps
module modpitch_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [5:0]  gain_in = '0;
  logic        tick_o;
  logic [19:0] wave_pitch;
  logic [7:0]  rd_counter;
  logic [3:0]  rd_incr;
  logic [5:0]  rd_pos;

  int checks = 0;
  int errors = 0;

  logic [6:0]  m_cnt = '0;
  logic [5:0]  m_pos = '0;
  int          m_phase = 0;
  logic [2:0]  m_tbl [32];

  always #2 clk = ~clk;

  modpitch_seq u_modpitch_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gain_in(gain_in), .tick_o(tick_o), .wave_pitch(wave_pitch),
    .rd_counter(rd_counter), .rd_incr(rd_incr), .rd_pos(rd_pos)
  );

  // {counter[6:0], gain[5:0], base[11:0]}
  localparam logic [24:0] VECS [8] = '{
    {7'h00, 6'd0,  12'h123},
    {7'h3F, 6'd63, 12'hFFF},
    {7'h40, 6'd63, 12'hFFF},
    {7'h7F, 6'd1,  12'h400},
    {7'h01, 6'd1,  12'h400},
    {7'h10, 6'd2,  12'h0AB},
    {7'h7C, 6'd5,  12'h800},
    {7'h20, 6'd32, 12'h001}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick_o);
  endtask

  function automatic logic [6:0] m_apply(input logic [2:0] c, input logic [6:0] v);
    case (c)
      3'd0: return v;
      3'd1: return v + 7'd1;
      3'd2: return v + 7'd2;
      3'd3: return v + 7'd4;
      3'd4: return 7'd0;
      3'd5: return v - 7'd4;
      3'd6: return v - 7'd2;
      default: return v - 7'd1;
    endcase
  endfunction

  function automatic int m_incr(input logic [2:0] c);
    case (c)
      3'd0: return 'h0;  3'd1: return 'h1;  3'd2: return 'h2;  3'd3: return 'h4;
      3'd4: return 'hC;  3'd5: return 'hC;  3'd6: return 'hE;  default: return 'hF;
    endcase
  endfunction

  function automatic int m_pitch(input logic [6:0] c, input int g, input int b);
    int cs, t;
    cs = int'(c);
    if (cs >= 64) cs = cs - 128;
    t = cs * g;
    if ((t & 'hF) != 0 && (t & 'h800) == 0) t = t + 'h20;
    t = t + 'h400;
    t = (t >>> 4) & 'hFF;
    return (b * t) & 'hFFFFF;
  endfunction

  task automatic fill(input int mode);
    logic [2:0] v;
    for (int j = 0; j < 32; j++) begin
      if (mode == 1)      v = 3'd1;
      else if (mode == 7) v = 3'd7;
      else                v = 3'(j);
      wr(3'd5, {5'd0, v});
      m_tbl[m_pos[5:1]] = v;
      m_pos = m_pos + 6'd2;
    end
    @(negedge clk);
    check("R7 fill wraps position", rd_pos, m_pos);
  endtask

  task automatic run_ticks(input int n, input int rate, input bit frc, input string req);
    int s;
    bit carry;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      s = m_phase + rate;
      carry = (s >= 4096) || frc;
      m_phase = s & 4095;
      if (carry) begin
        m_cnt = m_apply(m_tbl[m_pos[5:1]], m_cnt);
        m_pos = m_pos + 6'd1;
      end
      @(negedge clk);
      check({req, " counter"}, rd_counter, {1'b0, m_cnt});
      check({req, " position"}, rd_pos, m_pos);
      check("R11 increment readback", rd_incr, m_incr(m_tbl[m_pos[5:1]]));
    end
  endtask

  task automatic halt_now();
    wr(3'd3, 8'h80);
    m_phase = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int gap;
    logic [5:0] keep_pos;
    logic [3:0] keep_incr;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pitch", wave_pitch, 0);
    check("R1 counter", rd_counter, 0);
    check("R1 position", rd_pos, 0);

    // R2 tick spacing
    wait_tick();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tick_o);
    check("R2 tick spacing", gap, 16);

    // R9 / R10 pitch vectors, halted so nothing steps
    halt_now();
    for (int k = 0; k < 8; k++) begin
      wr(3'd4, {1'b0, VECS[k][24:18]});
      gain_in = VECS[k][17:12];
      wr(3'd0, VECS[k][7:0]);
      wr(3'd1, {4'd0, VECS[k][11:8]});
      wait_tick();
      wait_tick();
      repeat (12) @(negedge clk);
      check("R9 R10 pitch", wave_pitch,
            m_pitch(VECS[k][24:18], int'(VECS[k][17:12]), int'(VECS[k][11:0])));
      check("R6 R11 counter write readback", rd_counter, {1'b0, VECS[k][24:18]});
    end
    m_cnt = VECS[7][24:18];

    // R5 upward wrap
    fill(1);
    wr(3'd4, 8'h3F); m_cnt = 7'h3F;
    wr(3'd3, 8'h40);
    run_ticks(1, 0, 1'b1, "R5 wrap up");
    halt_now();

    // R5 downward wrap
    fill(7);
    wr(3'd4, 8'h40); m_cnt = 7'h40;
    wr(3'd3, 8'h40);
    run_ticks(1, 0, 1'b1, "R5 wrap down");
    halt_now();

    // R3 R4 R8 forced stepping over every code
    fill(0);
    wr(3'd4, 8'h00); m_cnt = '0;
    wr(3'd3, 8'h40);
    run_ticks(20, 0, 1'b1, "R3 R4 R8 forced steps");
    halt_now();

    // R3 half-rate carry from the phase accumulator, R12 rate high field
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h08);
    run_ticks(8, 'h800, 1'b0, "R3 R12 phase carry");
    halt_now();

    // R8 zero rate does not step
    wr(3'd3, 8'h00);
    run_ticks(3, 0, 1'b0, "R8 zero rate");

    // R7 table write ignored while running
    keep_pos = rd_pos;
    keep_incr = rd_incr;
    wr(3'd5, {5'd0, ~m_tbl[m_pos[5:1]]});
    repeat (2) @(negedge clk);
    check("R7 ignored write position", rd_pos, keep_pos);
    check("R7 ignored write entry", rd_incr, keep_incr);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule